// File: doc/BRIEF.md
# DRAM Device-Side Strobe Decoder

This block is a clocked behavioural model of the memory side of a page-mode dynamic RAM with a 4-bit data path and a small storage array. It sits on a testbench next to a memory controller under test. A fast system clock samples the four active-low strobes (row strobe, column strobe, write strobe and output strobe), together with the multiplexed address bus and the write data. The block finds the falling edge of each strobe by comparing two consecutive samples.

From the order in which the strobes fall, the model classifies every access as one of these:
- standby
- read
- early write
- delayed write (read-modify-write)
- row-only refresh
- column-before-row refresh
- hidden refresh

It latches the row and the column, commits write data at the correct strobe, and decides when the data pins would be driven. It reports the current access type as an encoded status and the row being worked on, so a bench can check the sequence the controller produced.

The high-impedance state is shown by a separate drive-enable output, `dq_oe`. While `dq_oe` is 0, the value on `dq_out` carries no meaning. There is no charge decay, so a refresh leaves the stored data unchanged.

Top module: `dram_strobe_model`

## Requirements
- R1: A row-strobe fall while the column strobe was already low on an earlier sample (not falling in the same sample) gives a column-before-row refresh. `cyc_type` becomes 5 and `act_row` shows the internal refresh counter. The address pins are ignored and `dq_oe` stays 0.
- R2: A row-strobe fall with the column strobe high latches the address pins as the row. `cyc_type` becomes 4 and `act_row` equals that row. While the column strobe stays high, `dq_oe` is 0 whatever the output strobe does.
- R3: If the write strobe is low before the column strobe falls, the access is an early write (`cyc_type` 2). The data sampled with the column fall is stored at the word with the latched row and that column.
- R4: `dq_oe` is 1 only when all of the following hold: a read has been latched, the column strobe is low, the write strobe is high and the output strobe is low. Otherwise `dq_oe` is 0.
- R5: A write-strobe fall after the column strobe has fallen in a read gives a delayed write (`cyc_type` 3). The data sampled with the write fall is stored at the latched row and column, and `dq_oe` drops to 0.
- R6: The refresh counter is 0 after reset. It rises by one after each column-before-row or hidden refresh, and wraps at 2^ROW_W.
- R7: A hidden refresh keeps the column strobe low after a read, raises the row strobe and lowers it again. `dq_out` and `dq_oe` keep the read data while the row strobe is high. The second row fall gives `cyc_type` 6 and `act_row` equal to the counter, with the read data still driven.
- R8: The column address follows the address pins while the row strobe is low and the column strobe is high. The value present in the sample where the column strobe falls is the column used.
- R9: A column-strobe fall with the write strobe high, after the row has been latched, gives a read (`cyc_type` 1). `dq_out` equals the stored word at that row and column.
- R10: When the row and column strobes are both high, `cyc_type` is 0. After reset, `cyc_type` is 0, `dq_oe` is 0 and `act_row` is 0.
- R11: Every result appears on the outputs after the second rising clock edge that follows the input change causing it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output strobe, active low |
| addr | input | ROW_W | Multiplexed row/column address (column uses the low COL_W bits) |
| dq_in | input | DW | Write data |
| dq_out | output | DW | Read data |
| dq_oe | output | 1 | Data drive enable; 0 means high impedance |
| cyc_type | output | 3 | Access type: 0 standby, 1 read, 2 early write, 3 delayed write, 4 row-only refresh, 5 column-before-row refresh, 6 hidden refresh |
| act_row | output | ROW_W | Row latched or refreshed by the current access |

## Verification
A strobe or address change is applied on a falling clock edge. The first rising edge registers it into the sampler and the edge decode sees it. The second rising edge commits the classification, the latch update, the array write and the drive enable. Every check therefore waits two falling edges after the stimulus before it samples the outputs, and writes are confirmed by later reads after the same delay. Inputs that take part in one decision, such as address before column fall or write strobe before column fall, are placed at least one sample ahead, so each edge is seen in a sample of its own.

// File: rtl/dram_strobe_pkg.sv
package dram_strobe_pkg;

    typedef enum logic [2:0] {
        CYC_IDLE = 3'd0,
        CYC_READ = 3'd1,
        CYC_EWR  = 3'd2,
        CYC_DWR  = 3'd3,
        CYC_ROR  = 3'd4,
        CYC_CBR  = 3'd5,
        CYC_HID  = 3'd6
    } cyc_e;

    localparam int NSTRB = 4;
    localparam int B_RAS = 3;
    localparam int B_CAS = 2;
    localparam int B_WE  = 1;
    localparam int B_OE  = 0;

endpackage

// File: rtl/strobe_sampler.sv
module strobe_sampler
    import dram_strobe_pkg::*;
#(
    parameter int AW = 3,
    parameter int DW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSTRB-1:0] strb_raw,
    input  logic [AW-1:0]    addr_raw,
    input  logic [DW-1:0]    data_raw,
    output logic [NSTRB-1:0] strb_cur,
    output logic [NSTRB-1:0] strb_fall,
    output logic [AW-1:0]    addr_s,
    output logic [DW-1:0]    data_s
);

    typedef struct packed {
        logic [NSTRB-1:0] cur;
        logic [NSTRB-1:0] prv;
        logic [AW-1:0]    a;
        logic [DW-1:0]    d;
    } smp_t;

    smp_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.prv = s_q.cur;
        s_d.cur = strb_raw;
        s_d.a   = addr_raw;
        s_d.d   = data_raw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{cur: '1, prv: '1, a: '0, d: '0};
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar i = 0; i < NSTRB; i++) begin : g_edge
        assign strb_fall[i] = s_q.prv[i] & ~s_q.cur[i];

        // R11: a strobe cannot be seen falling in two consecutive samples
        a_r11_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
            strb_fall[i] |=> !strb_fall[i]);
    end

    assign strb_cur = s_q.cur;
    assign addr_s   = s_q.a;
    assign data_s   = s_q.d;

endmodule

// File: rtl/cell_array.sv
module cell_array #(
    parameter int ROW_W = 3,
    parameter int COL_W = 2,
    parameter int DW    = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ROW_W+COL_W-1:0] wr_addr,
    input  logic [DW-1:0]          wr_data,
    input  logic [ROW_W+COL_W-1:0] rd_addr,
    output logic [DW-1:0]          rd_data
);

    localparam int DEPTH = 1 << (ROW_W + COL_W);

    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        always_comb begin
            mem_d[w] = mem_q[w];
            if (wr_en && (wr_addr == (ROW_W+COL_W)'(w))) begin
                mem_d[w] = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[w] <= '0;
            end else begin
                mem_q[w] <= mem_d[w];
            end
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/cycle_ctrl.sv
module cycle_ctrl
    import dram_strobe_pkg::*;
#(
    parameter int ROW_W = 3,
    parameter int COL_W = 2,
    parameter int DW    = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSTRB-1:0]       strb_cur,
    input  logic [NSTRB-1:B_WE]    strb_fall,
    input  logic [ROW_W-1:0]       addr_s,
    input  logic [DW-1:0]          data_s,
    input  logic [DW-1:0]          rd_data,
    output logic                   wr_en,
    output logic [ROW_W+COL_W-1:0] wr_addr,
    output logic [DW-1:0]          wr_data,
    output logic [ROW_W+COL_W-1:0] rd_addr,
    output cyc_e                   cyc,
    output logic [ROW_W-1:0]       row,
    output logic [DW-1:0]          dout,
    output logic                   drive
);

    typedef struct packed {
        cyc_e             cyc;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] cnt;
        logic             hold;
        logic [DW-1:0]    dout;
        logic             drive;
    } st_t;

    st_t st_d, st_q;

    logic ras_lo, cas_lo, we_lo, oe_lo;
    logic ras_fall, cas_fall, we_fall;
    logic cbr_start;
    logic [COL_W-1:0] a_col;

    assign ras_lo    = ~strb_cur[B_RAS];
    assign cas_lo    = ~strb_cur[B_CAS];
    assign we_lo     = ~strb_cur[B_WE];
    assign oe_lo     = ~strb_cur[B_OE];
    assign ras_fall  = strb_fall[B_RAS];
    assign cas_fall  = strb_fall[B_CAS];
    assign we_fall   = strb_fall[B_WE];
    assign a_col     = addr_s[COL_W-1:0];
    assign cbr_start = ras_fall && cas_lo && !cas_fall;

    always_comb begin
        st_d    = st_q;
        wr_en   = 1'b0;
        wr_addr = {st_q.row, st_q.col};
        wr_data = data_s;
        rd_addr = {st_q.row, a_col};

        if (ras_lo && !cas_lo) begin
            st_d.col = a_col;
        end

        if (ras_fall) begin
            if (cbr_start) begin
                st_d.cyc = st_q.hold ? CYC_HID : CYC_CBR;
                st_d.row = st_q.cnt;
                st_d.cnt = st_q.cnt + 1'b1;
            end else begin
                st_d.cyc  = CYC_ROR;
                st_d.row  = addr_s;
                st_d.hold = 1'b0;
            end
        end else if (ras_lo && cas_fall) begin
            st_d.col = a_col;
            if (we_lo) begin
                st_d.cyc  = CYC_EWR;
                st_d.hold = 1'b0;
                wr_en     = 1'b1;
                wr_addr   = {st_q.row, a_col};
            end else begin
                st_d.cyc  = CYC_READ;
                st_d.dout = rd_data;
                st_d.hold = 1'b1;
            end
        end else if (ras_lo && cas_lo && we_fall && st_q.cyc == CYC_READ) begin
            st_d.cyc = CYC_DWR;
            wr_en    = 1'b1;
            wr_addr  = {st_q.row, st_q.col};
        end else if (!ras_lo && !cas_lo) begin
            st_d.cyc = CYC_IDLE;
        end

        if (!cas_lo) begin
            st_d.hold = 1'b0;
        end

        st_d.drive = cas_lo && oe_lo && !we_lo && st_d.hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cyc: CYC_IDLE, row: '0, col: '0, cnt: '0,
                      hold: 1'b0, dout: '0, drive: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cyc   = st_q.cyc;
    assign row   = st_q.row;
    assign dout  = st_q.dout;
    assign drive = st_q.drive;

    // R4: drive only follows a sample with column low, write high, output low
    a_r4_drive_cond: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.drive |-> $past(cas_lo && oe_lo && !we_lo));

    // R1 / R6: refresh takes the counter row and advances the counter
    a_r6_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        cbr_start |=> (st_q.row == $past(st_q.cnt)) &&
                      (st_q.cnt == ROW_W'($past(st_q.cnt) + 1'b1)));

    // R3 / R5: an array write happens only with row, column and write strobes low
    a_r3_write_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (ras_lo && cas_lo && we_lo));

    // R7: a hidden refresh leaves the held read data untouched
    a_r7_hidden_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (cbr_start && st_q.hold) |=> $stable(st_q.dout));

    // R2: a row-only refresh never drives the data pins
    a_r2_ror_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cyc == CYC_ROR) |-> !st_q.drive);

endmodule

// File: rtl/dram_strobe_model.sv
module dram_strobe_model
    import dram_strobe_pkg::*;
#(
    parameter int ROW_W = 3,
    parameter int COL_W = 2,
    parameter int DW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [ROW_W-1:0] addr,
    input  logic [DW-1:0]    dq_in,
    output logic [DW-1:0]    dq_out,
    output logic             dq_oe,
    output logic [2:0]       cyc_type,
    output logic [ROW_W-1:0] act_row
);

    localparam int CW = ROW_W + COL_W;

    logic [NSTRB-1:0] strb_raw, strb_cur, strb_fall;
    logic [ROW_W-1:0] addr_s;
    logic [DW-1:0]    data_s, rd_data, wr_data;
    logic             wr_en;
    logic [CW-1:0]    wr_addr, rd_addr;
    cyc_e             cyc;

    assign strb_raw = {ras_n, cas_n, we_n, oe_n};

    strobe_sampler #(.AW(ROW_W), .DW(DW)) u_smp (
        .clk       (clk),
        .rst_n     (rst_n),
        .strb_raw  (strb_raw),
        .addr_raw  (addr),
        .data_raw  (dq_in),
        .strb_cur  (strb_cur),
        .strb_fall (strb_fall),
        .addr_s    (addr_s),
        .data_s    (data_s)
    );

    cycle_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DW(DW)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .strb_cur  (strb_cur),
        .strb_fall (strb_fall[NSTRB-1:B_WE]),
        .addr_s    (addr_s),
        .data_s    (data_s),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .cyc       (cyc),
        .row       (act_row),
        .dout      (dq_out),
        .drive     (dq_oe)
    );

    cell_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DW(DW)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign cyc_type = cyc;

    initial begin
        a_r8_col_fits: assert (COL_W <= ROW_W);
    end

endmodule

// File: tb/sim_dram_strobe_model.sv
module sim_dram_strobe_model;

    localparam int CLK_PERIOD = 10;
    localparam int ROW_W = 3;
    localparam int COL_W = 2;
    localparam int DW    = 4;
    localparam int NROW  = 1 << ROW_W;
    localparam int NCOL  = 1 << COL_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [ROW_W-1:0] addr = '0;
    logic [DW-1:0]    dq_in = '0;
    logic [DW-1:0]    dq_out;
    logic             dq_oe;
    logic [2:0]       cyc_type;
    logic [ROW_W-1:0] act_row;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    int exp_cnt = 0;
    logic [DW-1:0] model [NROW][NCOL];

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_strobe_model #(.ROW_W(ROW_W), .COL_W(COL_W), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .cyc_type(cyc_type), .act_row(act_row)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle_all();
        ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        step(2);
    endtask

    task automatic open_row(input int r);
        addr = ROW_W'(r);
        step(1);
        ras_n = 1'b0;
        step(2);
    endtask

    task automatic early_write(input int r, input int c, input int d);
        open_row(r);
        addr = ROW_W'(c); we_n = 1'b0; dq_in = DW'(d);
        step(1);
        cas_n = 1'b0;
        step(2);
        chk("R3 early write type", int'(cyc_type), 2);
        model[r][c] = DW'(d);
        idle_all();
    endtask

    task automatic read_open(input int r, input int c);
        open_row(r);
        addr = ROW_W'(c); oe_n = 1'b0;
        step(1);
        cas_n = 1'b0;
        step(2);
        chk("R9 read type", int'(cyc_type), 1);
        chk("R9 read data", int'(dq_out), int'(model[r][c]));
        chk("R4 drive on read", int'(dq_oe), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < NROW; r++)
            for (int c = 0; c < NCOL; c++)
                model[r][c] = '0;

        step(3);
        rst_n = 1'b1;
        step(2);
        chk("R10 reset type", int'(cyc_type), 0);
        chk("R10 reset drive", int'(dq_oe), 0);
        chk("R10 reset row", int'(act_row), 0);

        // R3: early write every word
        for (int r = 0; r < NROW; r++)
            for (int c = 0; c < NCOL; c++)
                early_write(r, c, (r * 5 + c * 3 + 1) % 16);

        // R9 / R4: read every word, then release output strobe
        for (int r = 0; r < NROW; r++)
            for (int c = 0; c < NCOL; c++) begin
                read_open(r, c);
                oe_n = 1'b1;
                step(2);
                chk("R4 drive off with output strobe high", int'(dq_oe), 0);
                idle_all();
                chk("R10 standby type", int'(cyc_type), 0);
            end

        // R5: delayed write on one word of each row
        for (int r = 0; r < NROW; r++) begin
            read_open(r, r % NCOL);
            we_n = 1'b0; dq_in = DW'(15 - r);
            step(2);
            chk("R5 delayed write type", int'(cyc_type), 3);
            chk("R5 drive off after write fall", int'(dq_oe), 0);
            model[r][r % NCOL] = DW'(15 - r);
            idle_all();
            read_open(r, r % NCOL);
            idle_all();
        end

        // R2: row-only refresh with output strobe low
        for (int r = 0; r < NROW; r++) begin
            oe_n = 1'b0;
            open_row(r);
            chk("R2 row-only type", int'(cyc_type), 4);
            chk("R2 row latched", int'(act_row), r);
            chk("R2 no drive", int'(dq_oe), 0);
            idle_all();
        end

        // R1 / R6: column-before-row refreshes, past the counter wrap
        for (int k = 0; k < NROW + 3; k++) begin
            oe_n = 1'b0;
            cas_n = 1'b0;
            step(2);
            addr = ROW_W'(7 - (k % NROW));
            step(1);
            ras_n = 1'b0;
            step(2);
            chk("R1 refresh type", int'(cyc_type), 5);
            chk("R6 refresh counter row", int'(act_row), exp_cnt % NROW);
            chk("R1 no drive", int'(dq_oe), 0);
            exp_cnt++;
            idle_all();
        end

        // R7: hidden refresh after a read
        read_open(3, 1);
        ras_n = 1'b1;
        step(2);
        chk("R7 drive held, row high", int'(dq_oe), 1);
        chk("R7 data held, row high", int'(dq_out), int'(model[3][1]));
        addr = ROW_W'(6);
        ras_n = 1'b0;
        step(2);
        chk("R7 hidden type", int'(cyc_type), 6);
        chk("R6 hidden counter row", int'(act_row), exp_cnt % NROW);
        chk("R7 drive during hidden", int'(dq_oe), 1);
        chk("R7 data during hidden", int'(dq_out), int'(model[3][1]));
        exp_cnt++;
        idle_all();

        // R8: flow-through column
        oe_n = 1'b0;
        open_row(5);
        addr = ROW_W'(0);
        step(1);
        addr = ROW_W'(2);
        step(1);
        cas_n = 1'b0;
        step(2);
        chk("R8 flow-through column data", int'(dq_out), int'(model[5][2]));
        idle_all();

        // R6: counter continues after the hidden refresh
        cas_n = 1'b0;
        step(2);
        ras_n = 1'b0;
        step(2);
        chk("R6 counter after hidden", int'(act_row), exp_cnt % NROW);
        exp_cnt++;
        idle_all();
        chk("R10 final standby", int'(cyc_type), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule